// File: doc/BRIEF.md
# Hotspot Translation Cache Controller

This block watches the stream of common-code instructions as they retire and turns the straight-line runs that follow a branch into configuration records. Each retired instruction carries an opaque configuration payload. While a run is open, the payloads are gathered in order in a temporary buffer. When the run closes and is long enough, the buffer is copied into a small cache. That cache is tagged by the program counter of the source architecture and is refilled in first-in, first-out order.

A separate lookup port takes a source program counter. On a hit it returns the stored run length and payloads, and it raises a stall signal. That signal freezes the upstream translator and the common-code processor while the stored configuration runs. The same stall also freezes the capture logic, so retirements seen during a hit are ignored.

Top module: `hotspot_tcache`

## Requirements
- R1: After reset the cache holds no valid entry: every lookup misses, `lk_len` and `lk_cfg` are zero and `stall` is low.
- R2: Capture only opens on the first supported, non-branch instruction that retires after a branch. Instructions with no branch before them since the last run closed are never captured. A branch that retires while a run is about to open keeps it about to open. An unsupported instruction in that position cancels it.
- R3: A closed run is committed only when it holds four or more instructions. Shorter runs are dropped. The entry's tag is the source PC of the first captured instruction.
- R4: An unsupported instruction closes an open run and is not part of it.
- R5: Up to SPEC_LIMIT branches (default 1) inside a run are captured as members. The next branch closes the run without being captured, and capture reopens on the instruction after it.
- R6: When a run reaches MAX_LEN instructions (default 8) it is committed at once. The instruction after it is not captured unless another branch comes first.
- R7: Commits fill entries in FIFO order. Once all ENTRIES slots (default 8) are used, the next commit overwrites the oldest entry, whose tag then misses.
- R8: On a hit, `lk_len` gives the run length. Slot i of `lk_cfg` (bits i*CFG_W upward) holds the payload of the i-th captured instruction, with slot 0 the first. Slots at or past the length read as zero. On a miss both outputs are zero.
- R9: `stall` is high exactly when a valid lookup hits. While it is high, retirements have no effect on capture.
- R10: A lookup in the same cycle as the commit of its tag returns a miss in that cycle and a hit from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rt_valid | input | 1 | An instruction retires this cycle |
| rt_pc | input | PC_W | Source-architecture PC of the retiring instruction |
| rt_cfg | input | CFG_W | Opaque configuration payload of the instruction |
| rt_ok | input | 1 | Instruction can be mapped onto the array |
| rt_br | input | 1 | Instruction is a branch |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Source PC to look up |
| lk_hit | output | 1 | Lookup found a valid entry |
| lk_len | output | LEN_W | Number of instructions in the hit entry |
| lk_cfg | output | MAX_LEN*CFG_W | Stored payloads, slot 0 first |
| stall | output | 1 | Freeze and bypass request on a hit |

## Verification
A single retirement sequence covers every way a run can end. It includes a plain prefix with no branch before it, a three-instruction run cut short by an unsupported instruction, a run with one branch inside it that a second branch closes, a run of exactly four instructions, and a run that fills the buffer. Lookups over that sequence separate tags that must miss from tags that must hit, with exact lengths and payload slots. Further sequences are fed in three situations: while a hit is held, during a commit that coincides with a lookup of the same tag, and in a series of commits that pushes the FIFO past its capacity, so that the oldest tag and the next-oldest tag give different answers.

// File: rtl/hc_pkg.sv
package hc_pkg;
   typedef enum logic [1:0] {
      CAP_IDLE  = 2'd0,
      CAP_ARMED = 2'd1,
      CAP_RUN   = 2'd2
   } cap_state_e;

   localparam int unsigned MIN_COMMIT = 4;
endpackage

// File: rtl/hc_capture.sv
module hc_capture
   import hc_pkg::*;
#(
   parameter int unsigned PC_W       = 32,
   parameter int unsigned CFG_W      = 32,
   parameter int unsigned MAX_LEN    = 8,
   parameter int unsigned SPEC_LIMIT = 1,
   localparam int unsigned LEN_W     = $clog2(MAX_LEN + 1),
   localparam int unsigned IDX_W     = $clog2(MAX_LEN),
   localparam int unsigned BR_W      = $clog2(SPEC_LIMIT + 2)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     hold,
   input  logic                     rt_valid,
   input  logic [PC_W-1:0]          rt_pc,
   input  logic [CFG_W-1:0]         rt_cfg,
   input  logic                     rt_ok,
   input  logic                     rt_br,
   output logic                     cm_valid,
   output logic [PC_W-1:0]          cm_tag,
   output logic [LEN_W-1:0]         cm_len,
   output logic [MAX_LEN*CFG_W-1:0] cm_data,
   output logic [LEN_W-1:0]         run_len
);
   cap_state_e         st, st_n;
   logic [LEN_W-1:0]   len, len_n;
   logic [BR_W-1:0]    brc, brc_n;
   logic [PC_W-1:0]    tag, tag_n;
   logic [CFG_W-1:0]   bufr  [MAX_LEN];
   logic [CFG_W-1:0]   buf_n [MAX_LEN];
   logic               end_run;

   always_comb begin
      st_n    = st;
      len_n   = len;
      brc_n   = brc;
      tag_n   = tag;
      end_run = 1'b0;
      for (int i = 0; i < MAX_LEN; i++) buf_n[i] = bufr[i];
      if (rt_valid && !hold) begin
         unique case (st)
            CAP_IDLE: begin
               if (rt_br) st_n = CAP_ARMED;
            end
            CAP_ARMED: begin
               if (!rt_ok) begin
                  st_n = CAP_IDLE;
               end else if (!rt_br) begin
                  st_n  = CAP_RUN;
                  tag_n = rt_pc;
                  for (int i = 0; i < MAX_LEN; i++) buf_n[i] = '0;
                  buf_n[0] = rt_cfg;
                  len_n = LEN_W'(1);
                  brc_n = '0;
               end
            end
            CAP_RUN: begin
               if (!rt_ok) begin
                  end_run = 1'b1;
                  st_n    = CAP_IDLE;
               end else if (rt_br && brc == BR_W'(SPEC_LIMIT)) begin
                  end_run = 1'b1;
                  st_n    = CAP_ARMED;
               end else begin
                  buf_n[len[IDX_W-1:0]] = rt_cfg;
                  len_n = len + LEN_W'(1);
                  if (rt_br) brc_n = brc + BR_W'(1);
                  if (len_n == LEN_W'(MAX_LEN)) begin
                     end_run = 1'b1;
                     st_n    = CAP_IDLE;
                  end
               end
            end
            default: st_n = CAP_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= CAP_IDLE;
         len <= '0;
         brc <= '0;
         tag <= '0;
         for (int i = 0; i < MAX_LEN; i++) bufr[i] <= '0;
      end else begin
         st  <= st_n;
         len <= len_n;
         brc <= brc_n;
         tag <= tag_n;
         for (int i = 0; i < MAX_LEN; i++) bufr[i] <= buf_n[i];
      end
   end

   for (genvar g = 0; g < MAX_LEN; g++) begin : g_pack
      assign cm_data[g*CFG_W +: CFG_W] = buf_n[g];
   end

   assign cm_valid = end_run && (len_n >= LEN_W'(MIN_COMMIT));
   assign cm_tag   = tag_n;
   assign cm_len   = len_n;
   assign run_len  = len;
endmodule

// File: rtl/hc_store.sv
module hc_store #(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned CFG_W   = 32,
   parameter int unsigned MAX_LEN = 8,
   parameter int unsigned ENTRIES = 8,
   localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1),
   localparam int unsigned PTR_W  = $clog2(ENTRIES),
   localparam int unsigned DATA_W = MAX_LEN * CFG_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cm_valid,
   input  logic [PC_W-1:0]    cm_tag,
   input  logic [LEN_W-1:0]   cm_len,
   input  logic [DATA_W-1:0]  cm_data,
   input  logic               lk_valid,
   input  logic [PC_W-1:0]    lk_pc,
   output logic               lk_hit,
   output logic [LEN_W-1:0]   lk_len,
   output logic [DATA_W-1:0]  lk_cfg,
   output logic [PTR_W-1:0]   wr_ptr
);
   logic [ENTRIES-1:0] vld;
   logic [ENTRIES-1:0] match;
   logic [PC_W-1:0]    tags [ENTRIES];
   logic [LEN_W-1:0]   lens [ENTRIES];
   logic [DATA_W-1:0]  data [ENTRIES];
   logic [PTR_W-1:0]   ptr_nx;
   logic [PTR_W-1:0]   sel;

   if ((1 << PTR_W) == ENTRIES) begin : g_wrap_pow2
      assign ptr_nx = wr_ptr + PTR_W'(1);
   end else begin : g_wrap_cmp
      assign ptr_nx = (wr_ptr == PTR_W'(ENTRIES - 1)) ? '0 : wr_ptr + PTR_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld    <= '0;
         wr_ptr <= '0;
      end else if (cm_valid) begin
         vld[wr_ptr] <= 1'b1;
         wr_ptr      <= ptr_nx;
      end
   end

   always_ff @(posedge clk) begin
      if (cm_valid) begin
         tags[wr_ptr] <= cm_tag;
         lens[wr_ptr] <= cm_len;
         data[wr_ptr] <= cm_data;
      end
   end

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign match[e] = vld[e] && (tags[e] == lk_pc);
   end

   always_comb begin
      sel = '0;
      for (int e = 0; e < ENTRIES; e++)
         if (match[e]) sel = PTR_W'(e);
   end

   assign lk_hit = lk_valid && (|match);
   assign lk_len = lk_hit ? lens[sel] : '0;
   assign lk_cfg = lk_hit ? data[sel] : '0;
endmodule

// File: rtl/hotspot_tcache.sv
module hotspot_tcache #(
   parameter int unsigned PC_W       = 32,
   parameter int unsigned CFG_W      = 32,
   parameter int unsigned MAX_LEN    = 8,
   parameter int unsigned ENTRIES    = 8,
   parameter int unsigned SPEC_LIMIT = 1,
   localparam int unsigned LEN_W     = $clog2(MAX_LEN + 1),
   localparam int unsigned PTR_W     = $clog2(ENTRIES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rt_valid,
   input  logic [PC_W-1:0]          rt_pc,
   input  logic [CFG_W-1:0]         rt_cfg,
   input  logic                     rt_ok,
   input  logic                     rt_br,
   input  logic                     lk_valid,
   input  logic [PC_W-1:0]          lk_pc,
   output logic                     lk_hit,
   output logic [LEN_W-1:0]         lk_len,
   output logic [MAX_LEN*CFG_W-1:0] lk_cfg,
   output logic                     stall
);
   if (MAX_LEN < hc_pkg::MIN_COMMIT) begin : g_bad_len
      $error("MAX_LEN must allow a committable run");
   end
   if (ENTRIES < 2) begin : g_bad_entries
      $error("ENTRIES must be at least 2");
   end
   if (PC_W < 1 || CFG_W < 1) begin : g_bad_width
      $error("PC_W and CFG_W must be positive");
   end

   logic                     cm_valid;
   logic [PC_W-1:0]          cm_tag;
   logic [LEN_W-1:0]         cm_len;
   logic [MAX_LEN*CFG_W-1:0] cm_data;
   logic [LEN_W-1:0]         cap_len;
   logic [PTR_W-1:0]         wr_ptr;

   hc_capture #(
      .PC_W(PC_W), .CFG_W(CFG_W), .MAX_LEN(MAX_LEN), .SPEC_LIMIT(SPEC_LIMIT)
   ) u_cap (
      .clk(clk), .rst_n(rst_n), .hold(stall),
      .rt_valid(rt_valid), .rt_pc(rt_pc), .rt_cfg(rt_cfg),
      .rt_ok(rt_ok), .rt_br(rt_br),
      .cm_valid(cm_valid), .cm_tag(cm_tag), .cm_len(cm_len),
      .cm_data(cm_data), .run_len(cap_len)
   );

   hc_store #(
      .PC_W(PC_W), .CFG_W(CFG_W), .MAX_LEN(MAX_LEN), .ENTRIES(ENTRIES)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .cm_valid(cm_valid), .cm_tag(cm_tag), .cm_len(cm_len), .cm_data(cm_data),
      .lk_valid(lk_valid), .lk_pc(lk_pc),
      .lk_hit(lk_hit), .lk_len(lk_len), .lk_cfg(lk_cfg), .wr_ptr(wr_ptr)
   );

   assign stall = lk_hit;
endmodule

// File: rtl/hotspot_tcache_chk.sv
module hotspot_tcache_chk #(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned MAX_LEN = 8,
   parameter int unsigned ENTRIES = 8,
   localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1),
   localparam int unsigned PTR_W  = $clog2(ENTRIES)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_valid,
   input logic [PC_W-1:0]  lk_pc,
   input logic             lk_hit,
   input logic [LEN_W-1:0] lk_len,
   input logic             stall,
   input logic             cm_valid,
   input logic [PC_W-1:0]  cm_tag,
   input logic [LEN_W-1:0] cm_len,
   input logic [LEN_W-1:0] cap_len,
   input logic [PTR_W-1:0] wr_ptr
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> (!lk_hit && !stall));

   p_commit_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cm_valid |-> (cm_len > LEN_W'(3) && cm_len <= LEN_W'(MAX_LEN)));

   p_hit_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_len > LEN_W'(3) && lk_len <= LEN_W'(MAX_LEN)));

   p_stall_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable(cap_len));

   p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cm_valid |=> $stable(wr_ptr));

   p_commit_visible_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cm_valid |=> (!(lk_valid && lk_pc == $past(cm_tag)) || lk_hit));
endmodule

bind hotspot_tcache hotspot_tcache_chk #(
   .PC_W(PC_W), .MAX_LEN(MAX_LEN), .ENTRIES(ENTRIES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
   .lk_hit(lk_hit), .lk_len(lk_len), .stall(stall),
   .cm_valid(cm_valid), .cm_tag(cm_tag), .cm_len(cm_len),
   .cap_len(cap_len), .wr_ptr(wr_ptr)
);

// File: tb/hotspot_tcache_test.sv
module hotspot_tcache_test;
   localparam int CLK_PERIOD = 10;
   localparam int PC_W = 32;
   localparam int CFG_W = 32;
   localparam int MAX_LEN = 8;
   localparam int LEN_W = $clog2(MAX_LEN + 1);

   // retire vectors: {pc, supported, branch}
   localparam int NV = 29;
   localparam logic [33:0] VEC [NV] = '{
      {32'h100, 2'b10}, {32'h104, 2'b10}, {32'h108, 2'b11},
      {32'h200, 2'b10}, {32'h204, 2'b10}, {32'h208, 2'b10}, {32'h20C, 2'b00},
      {32'h210, 2'b10}, {32'h214, 2'b11},
      {32'h300, 2'b10}, {32'h304, 2'b10}, {32'h308, 2'b11}, {32'h30C, 2'b10},
      {32'h310, 2'b11},
      {32'h400, 2'b10}, {32'h404, 2'b10}, {32'h408, 2'b10}, {32'h40C, 2'b10},
      {32'h410, 2'b00}, {32'h418, 2'b11},
      {32'h500, 2'b10}, {32'h504, 2'b10}, {32'h508, 2'b10}, {32'h50C, 2'b10},
      {32'h510, 2'b10}, {32'h514, 2'b10}, {32'h518, 2'b10}, {32'h51C, 2'b10},
      {32'h520, 2'b10}
   };
   // expected lookups: {pc, hit, len}
   localparam int NL = 7;
   localparam logic [36:0] LKV [NL] = '{
      {32'h100, 1'b0, 4'd0}, {32'h200, 1'b0, 4'd0}, {32'h210, 1'b0, 4'd0},
      {32'h300, 1'b1, 4'd4}, {32'h400, 1'b1, 4'd4}, {32'h500, 1'b1, 4'd8},
      {32'h520, 1'b0, 4'd0}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic rt_valid = 1'b0, rt_ok = 1'b0, rt_br = 1'b0, lk_valid = 1'b0;
   logic [PC_W-1:0] rt_pc = '0, lk_pc = '0;
   logic [CFG_W-1:0] rt_cfg = '0;
   logic lk_hit, stall;
   logic [LEN_W-1:0] lk_len;
   logic [MAX_LEN*CFG_W-1:0] lk_cfg;
   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hotspot_tcache uut (
      .clk(clk), .rst_n(rst_n), .rt_valid(rt_valid), .rt_pc(rt_pc),
      .rt_cfg(rt_cfg), .rt_ok(rt_ok), .rt_br(rt_br),
      .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_hit(lk_hit),
      .lk_len(lk_len), .lk_cfg(lk_cfg), .stall(stall)
   );

   function automatic logic [CFG_W-1:0] pay(input logic [PC_W-1:0] pc);
      return pc ^ 32'h5A5A_0000;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic retire(input logic [PC_W-1:0] pc, input logic ok, input logic br);
      @(negedge clk);
      rt_valid = 1'b1; rt_pc = pc; rt_cfg = pay(pc); rt_ok = ok; rt_br = br;
   endtask

   task automatic quiet();
      @(negedge clk);
      rt_valid = 1'b0;
   endtask

   task automatic look(input logic [PC_W-1:0] pc);
      lk_valid = 1'b1; lk_pc = pc;
      #1;
   endtask

   task automatic run4(input logic [PC_W-1:0] base);
      retire(base - 32'h4, 1'b1, 1'b1);
      for (int k = 0; k < 4; k++) retire(base + 32'(4*k), 1'b1, 1'b0);
      retire(base + 32'h10, 1'b0, 1'b0);
      quiet();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: empty after reset
      @(negedge clk); look(32'h300);
      check("R1 hit", 64'(lk_hit), 64'd0);
      check("R1 stall", 64'(stall), 64'd0);
      check("R1 cfg", 64'(lk_cfg[63:0]), 64'd0);
      lk_valid = 1'b0;

      for (int i = 0; i < NV; i++) retire(VEC[i][33:2], VEC[i][1], VEC[i][0]);
      quiet();

      // R2 R3 R4 R5 R6: hit/len per lookup vector
      for (int i = 0; i < NL; i++) begin
         look(LKV[i][36:5]);
         check("R3 hit", 64'(lk_hit), 64'(LKV[i][4]));
         check("R3 len", 64'(lk_len), 64'(LKV[i][3:0]));
         check("R9 stall", 64'(stall), 64'(LKV[i][4]));
      end
      // R5: inner branch kept, closing branch dropped
      look(32'h300);
      check("R5 slot0", 64'(lk_cfg[0 +: 32]), 64'(pay(32'h300)));
      check("R5 slot2", 64'(lk_cfg[64 +: 32]), 64'(pay(32'h308)));
      check("R5 slot3", 64'(lk_cfg[96 +: 32]), 64'(pay(32'h30C)));
      check("R8 slot4 zero", 64'(lk_cfg[128 +: 32]), 64'd0);
      // R4: unsupported excluded
      look(32'h400);
      check("R4 slot3", 64'(lk_cfg[96 +: 32]), 64'(pay(32'h40C)));
      check("R4 slot4", 64'(lk_cfg[128 +: 32]), 64'd0);
      // R6: full run
      look(32'h500);
      check("R6 slot7", 64'(lk_cfg[224 +: 32]), 64'(pay(32'h51C)));
      check("R8 slot1", 64'(lk_cfg[32 +: 32]), 64'(pay(32'h504)));

      // R9: retirements during a hit are ignored
      look(32'h300);
      retire(32'h6FC, 1'b1, 1'b1);
      for (int k = 0; k < 5; k++) retire(32'h700 + 32'(4*k), 1'b1, 1'b0);
      retire(32'h714, 1'b0, 1'b0);
      quiet();
      check("R9 stall held", 64'(stall), 64'd1);
      lk_valid = 1'b0;
      @(negedge clk); look(32'h700);
      check("R9 ignored", 64'(lk_hit), 64'd0);
      lk_valid = 1'b0;

      // R10: same-cycle commit and lookup
      retire(32'h8FC, 1'b1, 1'b1);
      for (int k = 0; k < 4; k++) retire(32'h900 + 32'(4*k), 1'b1, 1'b0);
      retire(32'h910, 1'b0, 1'b0);
      look(32'h900);
      check("R10 miss same cycle", 64'(lk_hit), 64'd0);
      @(negedge clk); rt_valid = 1'b0; #1;
      check("R10 hit next cycle", 64'(lk_hit), 64'd1);
      lk_valid = 1'b0;

      // R7: four more commits fill the cache, the fifth evicts the oldest
      for (int k = 0; k < 4; k++) run4(32'hA00 + 32'(k * 32'h40));
      look(32'h300);
      check("R7 oldest kept when full", 64'(lk_hit), 64'd1);
      lk_valid = 1'b0;
      run4(32'hB00);
      look(32'h300);
      check("R7 oldest evicted", 64'(lk_hit), 64'd0);
      look(32'h400);
      check("R7 next kept", 64'(lk_hit), 64'd1);
      look(32'hB00);
      check("R7 new entry", 64'(lk_hit), 64'd1);
      lk_valid = 1'b0;

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule